// File: doc/BRIEF.md
# AGC Sample Output Port

This block carries samples from two gain-control units out over one 16-bit parallel port. Each unit hands over an in-phase word, a quadrature word and the 12-bit gain word its multiplier is using. The block holds one pending sample per unit, raises a request toward the reader, and when the reader acknowledges it plays out the I word and then the Q word on consecutive cycles. If the unit's gain has moved since its previous sample, a third cycle carries a signal-strength word, which is the bit-inverse of the gain.

A two-bit tag travels with every word. Its low bit names the source unit and its high bit marks the signal-strength word. A mode input hands the port over to per-channel output, and in that case this block stays silent. Two enable inputs decide which of the two units may place samples on the port.

Top module: `agc_port`

## Requirements
- R1: With `agc_mode` high, no transfer in progress and at least one pending sample, `port_req` is high. When `port_req` and `port_ack` are both high at a rising edge, that edge drives the I word with `port_iq` high, and the next edge drives the Q word with `port_iq` low.
- R2: `port_iq` is high for exactly the I-word cycle and low in every other cycle.
- R3: When the transferred sample carries the gain-changed flag, the cycle after the Q word drives `port_data[15:4]` = bitwise inverse of the gain word and `port_data[3:0]` = 0. Without the flag, no third word follows.
- R4: A sample carries the gain-changed flag when its gain differs from the gain of the previous accepted sample of the same unit (reference value 0 after reset). The flag stays set across overwrites until that unit's sample is granted.
- R5: `port_tag[0]` is the source (0 = unit A, 1 = unit B). `port_tag[1]` is 1 only for the signal-strength word. In cycles with no word, `port_data`, `port_iq` and `port_tag` are all 0.
- R6: When both units have a pending sample, unit A is granted first.
- R7: While a unit's enable is low, its arriving samples are discarded and its pending sample is dropped.
- R8: While `agc_mode` is low, `port_req` is low, all arriving samples are discarded and pending samples are dropped.
- R9: Each unit holds a single pending sample. A newer sample from the same unit replaces the older one.
- R10: `port_req` is low while a transfer is in progress. A sample that arrives in the grant cycle or later is kept pending for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agc_mode | input | 1 | 1 = gain-unit output, 0 = port owned by channel output |
| en_a | input | 1 | Include unit A on the port |
| en_b | input | 1 | Include unit B on the port |
| a_vld | input | 1 | Unit A sample strobe |
| a_i | input | 16 | Unit A I word |
| a_q | input | 16 | Unit A Q word |
| a_gain | input | 12 | Unit A gain word |
| b_vld | input | 1 | Unit B sample strobe |
| b_i | input | 16 | Unit B I word |
| b_q | input | 16 | Unit B Q word |
| b_gain | input | 12 | Unit B gain word |
| port_req | output | 1 | Data available toward the reader |
| port_ack | input | 1 | Reader acknowledge |
| port_data | output | 16 | Port data word |
| port_iq | output | 1 | High during the I word |
| port_tag | output | 2 | Bit 0 source unit, bit 1 signal-strength word |

## Verification
The assertions assume that `agc_mode` does not change while a word sequence is being played out, and that the reader raises `port_ack` only as a reply to a request. The stimulus changes mode and enables only between transfers and drives all inputs on the falling edge. One case deliberately holds `port_ack` high with no request, to show that it is ignored. Samples that arrive during a grant come from a dedicated task, so that an overwrite in the same cycle as a take is covered.

// File: rtl/agc_port_pkg.sv
package agc_port_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_QW   = 2'd1,
      PS_RSSI = 2'd2
   } port_st_e;

   localparam int TAG_W = 2;
endpackage

// File: rtl/agc_slot.sv
module agc_slot #(
   parameter int DATA_W = 16,
   parameter int GAIN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_en,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_i,
   input  logic [DATA_W-1:0] smp_q,
   input  logic [GAIN_W-1:0] smp_gain,
   input  logic              take,
   output logic              pend,
   output logic [DATA_W-1:0] hold_i,
   output logic [DATA_W-1:0] hold_q,
   output logic [GAIN_W-1:0] hold_gain,
   output logic              upd
);
   logic [GAIN_W-1:0] last_gain;
   logic              new_acc;
   logic              upd_base;

   assign new_acc  = smp_vld && accept_en;
   assign upd_base = take ? 1'b0 : upd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         upd       <= 1'b0;
         last_gain <= '0;
         hold_i    <= '0;
         hold_q    <= '0;
         hold_gain <= '0;
      end else if (!accept_en) begin
         pend <= 1'b0;
         upd  <= 1'b0;
      end else if (new_acc) begin
         pend      <= 1'b1;
         hold_i    <= smp_i;
         hold_q    <= smp_q;
         hold_gain <= smp_gain;
         last_gain <= smp_gain;
         upd       <= upd_base | (smp_gain != last_gain);
      end else if (take) begin
         pend <= 1'b0;
         upd  <= 1'b0;
      end
   end
endmodule

// File: rtl/agc_pick.sv
module agc_pick #(
   parameter int N_SRC = 2,
   localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] pend,
   output logic             any,
   output logic [SEL_W-1:0] sel
);
   always_comb begin
      sel = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (pend[k]) sel = SEL_W'(k);
      end
   end

   assign any = |pend;
endmodule

// File: rtl/agc_tx.sv
module agc_tx
   import agc_port_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int GAIN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant,
   input  logic              g_src,
   input  logic [DATA_W-1:0] g_i,
   input  logic [DATA_W-1:0] g_q,
   input  logic [GAIN_W-1:0] g_gain,
   input  logic              g_upd,
   output logic              busy,
   output logic [DATA_W-1:0] data_o,
   output logic              iq_o,
   output logic [TAG_W-1:0]  tag_o
);
   port_st_e          st;
   logic              c_src;
   logic              c_upd;
   logic [DATA_W-1:0] c_q;
   logic [GAIN_W-1:0] c_gain;
   logic [DATA_W-1:0] rssi_w;

   generate
      if (DATA_W == GAIN_W) begin : g_no_pad
         assign rssi_w = ~c_gain;
      end else begin : g_pad
         assign rssi_w = {~c_gain, {(DATA_W-GAIN_W){1'b0}}};
      end
   endgenerate

   assign busy = (st != PS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= PS_IDLE;
         c_src  <= 1'b0;
         c_upd  <= 1'b0;
         c_q    <= '0;
         c_gain <= '0;
         data_o <= '0;
         iq_o   <= 1'b0;
         tag_o  <= '0;
      end else begin
         case (st)
            PS_IDLE: begin
               if (grant) begin
                  data_o <= g_i;
                  iq_o   <= 1'b1;
                  tag_o  <= {1'b0, g_src};
                  c_src  <= g_src;
                  c_q    <= g_q;
                  c_gain <= g_gain;
                  c_upd  <= g_upd;
                  st     <= PS_QW;
               end else begin
                  data_o <= '0;
                  iq_o   <= 1'b0;
                  tag_o  <= '0;
               end
            end
            PS_QW: begin
               data_o <= c_q;
               iq_o   <= 1'b0;
               tag_o  <= {1'b0, c_src};
               st     <= c_upd ? PS_RSSI : PS_IDLE;
            end
            PS_RSSI: begin
               data_o <= rssi_w;
               iq_o   <= 1'b0;
               tag_o  <= {1'b1, c_src};
               st     <= PS_IDLE;
            end
            default: begin
               data_o <= '0;
               iq_o   <= 1'b0;
               tag_o  <= '0;
               st     <= PS_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/agc_port.sv
module agc_port #(
   parameter int DATA_W = 16,
   parameter int GAIN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              agc_mode,
   input  logic              en_a,
   input  logic              en_b,
   input  logic              a_vld,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] a_q,
   input  logic [GAIN_W-1:0] a_gain,
   input  logic              b_vld,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] b_q,
   input  logic [GAIN_W-1:0] b_gain,
   output logic              port_req,
   input  logic              port_ack,
   output logic [DATA_W-1:0] port_data,
   output logic              port_iq,
   output logic [1:0]        port_tag
);
   localparam int N_SRC = 2;
   localparam int SEL_W = 1;

   generate
      if (GAIN_W < 1 || GAIN_W > DATA_W) begin : g_bad_gain_w
         $error("agc_port: GAIN_W must lie in 1..DATA_W");
      end
      if (DATA_W > 63) begin : g_bad_data_w
         $error("agc_port: DATA_W must not exceed 63");
      end
   endgenerate

   logic [N_SRC-1:0]  in_vld;
   logic [N_SRC-1:0]  in_en;
   logic [DATA_W-1:0] in_i    [N_SRC];
   logic [DATA_W-1:0] in_q    [N_SRC];
   logic [GAIN_W-1:0] in_gain [N_SRC];
   logic [N_SRC-1:0]  pend;
   logic [N_SRC-1:0]  upd;
   logic [N_SRC-1:0]  take;
   logic [DATA_W-1:0] h_i     [N_SRC];
   logic [DATA_W-1:0] h_q     [N_SRC];
   logic [GAIN_W-1:0] h_gain  [N_SRC];
   logic              any_pend;
   logic [SEL_W-1:0]  sel;
   logic              busy;
   logic              grant;

   assign in_vld     = {b_vld, a_vld};
   assign in_en      = {en_b, en_a} & {N_SRC{agc_mode}};
   assign in_i[0]    = a_i;
   assign in_i[1]    = b_i;
   assign in_q[0]    = a_q;
   assign in_q[1]    = b_q;
   assign in_gain[0] = a_gain;
   assign in_gain[1] = b_gain;

   generate
      for (genvar k = 0; k < N_SRC; k++) begin : g_slot
         assign take[k] = grant && (sel == SEL_W'(k));
         agc_slot #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept_en (in_en[k]),
            .smp_vld   (in_vld[k]),
            .smp_i     (in_i[k]),
            .smp_q     (in_q[k]),
            .smp_gain  (in_gain[k]),
            .take      (take[k]),
            .pend      (pend[k]),
            .hold_i    (h_i[k]),
            .hold_q    (h_q[k]),
            .hold_gain (h_gain[k]),
            .upd       (upd[k])
         );
      end
   endgenerate

   agc_pick #(.N_SRC(N_SRC)) u_pick (
      .pend (pend),
      .any  (any_pend),
      .sel  (sel)
   );

   assign port_req = agc_mode && !busy && any_pend;
   assign grant    = port_req && port_ack;

   agc_tx #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .grant  (grant),
      .g_src  (sel),
      .g_i    (h_i[sel]),
      .g_q    (h_q[sel]),
      .g_gain (h_gain[sel]),
      .g_upd  (upd[sel]),
      .busy   (busy),
      .data_o (port_data),
      .iq_o   (port_iq),
      .tag_o  (port_tag)
   );
endmodule

module agc_port_chk #(
   parameter int DATA_W = 16,
   parameter int GAIN_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              agc_mode,
   input logic              port_req,
   input logic              port_ack,
   input logic [DATA_W-1:0] port_data,
   input logic              port_iq,
   input logic [1:0]        port_tag
);
   localparam int PAD_W = DATA_W - GAIN_W;
   localparam logic [DATA_W-1:0] PAD_MASK = DATA_W'((64'd1 << PAD_W) - 64'd1);

   p_i_after_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (port_req && port_ack) |=> (port_iq && !port_tag[1]));

   p_iq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      port_iq |=> !port_iq);

   p_rssi_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      port_tag[1] |-> ((port_data & PAD_MASK) == '0));

   p_rssi_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      port_tag[1] |=> !port_tag[1]);

   p_q_follows_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_iq |=> (!port_tag[1] && $stable(port_tag[0])));

   p_rssi_not_iq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_tag[1] |-> !port_iq);

   p_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !agc_mode |-> !port_req);

   p_no_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      port_iq |-> !port_req);
endmodule

bind agc_port agc_port_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .agc_mode  (agc_mode),
   .port_req  (port_req),
   .port_ack  (port_ack),
   .port_data (port_data),
   .port_iq   (port_iq),
   .port_tag  (port_tag)
);

// File: tb/tb_agc_port.sv
module tb_agc_port;
   localparam int DW = 16;
   localparam int GW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          agc_mode = 1'b0;
   logic          en_a = 1'b0, en_b = 1'b0;
   logic          a_vld = 1'b0, b_vld = 1'b0;
   logic [DW-1:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
   logic [GW-1:0] a_gain = '0, b_gain = '0;
   logic          port_req;
   logic          port_ack = 1'b0;
   logic [DW-1:0] port_data;
   logic          port_iq;
   logic [1:0]    port_tag;

   always #2 clk = ~clk;

   agc_port #(.DATA_W(DW), .GAIN_W(GW)) dut (.*);

   typedef struct {
      logic [DW-1:0] d;
      logic          iq;
      logic [1:0]    tg;
      string         rq;
   } exp_t;

   exp_t exq[$];
   int   total = 0;
   int   bad = 0;
   logic mon_on = 1'b0;

   logic          m_pend [2];
   logic          m_upd  [2];
   logic [DW-1:0] m_i    [2];
   logic [DW-1:0] m_q    [2];
   logic [GW-1:0] m_g    [2];
   logic [GW-1:0] m_last [2];

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // monitor: one output cycle per posedge, sampled 1 ns later
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (exq.size() > 0) begin
               exp_t e;
               e = exq.pop_front();
               check(e.rq, {13'd0, port_iq, port_tag, port_data}, {13'd0, e.iq, e.tg, e.d});
            end else begin
               check("R5 idle cycle", {13'd0, port_iq, port_tag, port_data}, 32'd0);
            end
         end
      end
   end

   function automatic logic src_en(input int s);
      return (s == 0) ? en_a : en_b;
   endfunction

   function automatic void model_accept(input int s, input logic [DW-1:0] i,
                                        input logic [DW-1:0] q, input logic [GW-1:0] g);
      if (agc_mode && src_en(s)) begin
         m_upd[s]  = m_upd[s] | (g != m_last[s]);
         m_last[s] = g;
         m_pend[s] = 1'b1;
         m_i[s]    = i;
         m_q[s]    = q;
         m_g[s]    = g;
      end
   endfunction

   task automatic drive_smp(input int s, input logic [DW-1:0] i,
                            input logic [DW-1:0] q, input logic [GW-1:0] g);
      if (s == 0) begin a_vld = 1'b1; a_i = i; a_q = q; a_gain = g; end
      else        begin b_vld = 1'b1; b_i = i; b_q = q; b_gain = g; end
   endtask

   task automatic send(input int s, input logic [DW-1:0] i,
                       input logic [DW-1:0] q, input logic [GW-1:0] g);
      @(negedge clk);
      drive_smp(s, i, q, g);
      model_accept(s, i, q, g);
      @(posedge clk);
      #1;
      a_vld = 1'b0;
      b_vld = 1'b0;
   endtask

   // driver: grants one transfer and queues the words the requirements predict
   task automatic grab(input string why, input bit with_smp = 1'b0, input int ss = 0,
                       input logic [DW-1:0] si = '0, input logic [DW-1:0] sq = '0,
                       input logic [GW-1:0] sg = '0);
      logic exp_req;
      int   s;
      int   n;
      exp_t e;
      @(negedge clk);
      exp_req = agc_mode && (m_pend[0] || m_pend[1]);
      check({"R1 req ", why}, {31'd0, port_req}, {31'd0, exp_req});
      if (!exp_req) return;
      s = m_pend[0] ? 0 : 1;  // R6 unit A first
      e.d = m_i[s]; e.iq = 1'b1; e.tg = {1'b0, s[0]}; e.rq = {"R1 I word ", why};
      exq.push_back(e);
      e.d = m_q[s]; e.iq = 1'b0; e.tg = {1'b0, s[0]}; e.rq = {"R1 Q word ", why};
      exq.push_back(e);
      n = 2;
      if (m_upd[s]) begin
         e.d = {~m_g[s], 4'b0000}; e.iq = 1'b0; e.tg = {1'b1, s[0]};
         e.rq = {"R3 RSSI word ", why};
         exq.push_back(e);
         n = 3;
      end
      m_pend[s] = 1'b0;
      m_upd[s]  = 1'b0;
      port_ack  = 1'b1;
      if (with_smp) begin
         drive_smp(ss, si, sq, sg);
         model_accept(ss, si, sq, sg);
      end
      @(posedge clk);
      #1;
      port_ack = 1'b0;
      a_vld = 1'b0;
      b_vld = 1'b0;
      check({"R10 req low in transfer ", why}, {31'd0, port_req}, 32'd0);
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic set_en(input int s, input logic v);
      @(negedge clk);
      if (s == 0) en_a = v; else en_b = v;
      if (!v) begin m_pend[s] = 1'b0; m_upd[s] = 1'b0; end
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk);
      agc_mode = v;
      if (!v) for (int k = 0; k < 2; k++) begin m_pend[k] = 1'b0; m_upd[k] = 1'b0; end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int k = 0; k < 2; k++) begin
         m_pend[k] = 1'b0; m_upd[k] = 1'b0; m_i[k] = '0; m_q[k] = '0;
         m_g[k] = '0; m_last[k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R5 reset data", {15'd0, port_data}, 32'd0);
      check("R5 reset iq/tag", {29'd0, port_iq, port_tag}, 32'd0);
      check("R1 reset req", {31'd0, port_req}, 32'd0);
      mon_on = 1'b1;

      agc_mode = 1'b1; en_a = 1'b1; en_b = 1'b1;
      // R4: gain moves 0 -> 5, RSSI follows
      send(0, 16'h1111, 16'h2222, 12'h005);
      grab("R4 first gain change");
      // R4: same gain, no third word
      send(0, 16'h3333, 16'h4444, 12'h005);
      grab("R4 unchanged gain");
      // R5: unit B tag, gain equals reset reference
      send(1, 16'hB001, 16'hB002, 12'h000);
      grab("R5 unit B no RSSI");
      // R6: both pending, A first, then B with RSSI tag 11
      send(1, 16'hB101, 16'hB102, 12'h123);
      send(0, 16'hA101, 16'hA102, 12'h005);
      grab("R6 A before B");
      grab("R6 B after A");
      // R9: overwrite keeps newest data and sticky flag
      send(0, 16'hDEAD, 16'hBEEF, 12'h7FF);
      send(0, 16'hCAFE, 16'hF00D, 12'h7FF);
      grab("R9 overwrite");
      // R1: ack without a request is ignored
      @(negedge clk);
      port_ack = 1'b1;
      check("R1 no req when empty", {31'd0, port_req}, 32'd0);
      @(posedge clk);
      #1;
      port_ack = 1'b0;
      // R7: disable drops pending and blocks arrivals
      send(1, 16'h0B0B, 16'h0C0C, 12'h0AA);
      set_en(1, 1'b0);
      grab("R7 dropped on disable");
      send(1, 16'h0D0D, 16'h0E0E, 12'h0BB);
      set_en(1, 1'b1);
      grab("R7 discarded while disabled");
      // R8: channel mode silences the port
      send(0, 16'h5555, 16'h6666, 12'h321);
      set_mode(1'b0);
      grab("R8 dropped in channel mode");
      send(0, 16'h7777, 16'h8888, 12'h456);
      set_mode(1'b1);
      grab("R8 discarded in channel mode");
      // R10: sample arriving in grant cycle stays pending
      send(0, 16'h0101, 16'h0202, 12'h100);
      grab("R10 grant with same-cycle sample", 1'b1, 0, 16'h0303, 16'h0404, 12'h100);
      grab("R10 held sample");
      send(1, 16'h0909, 16'h0A0A, 12'h200);
      grab("R10 grant with B sample", 1'b1, 1, 16'h0B0B, 16'h0C0C, 12'h201);
      grab("R10 held B sample changed gain");
      // R3: all-ones gain gives zero RSSI; back-to-back grants
      send(0, 16'hFFFF, 16'h8000, 12'hFFF);
      send(1, 16'h7FFF, 16'h0001, 12'hFFF);
      grab("R3 all-ones gain A");
      grab("R3 all-ones gain B");
      repeat (6) @(posedge clk);
      #1;
      check("R1 queue drained", exq.size(), 32'd0);
      summary();
      $finish;
   end
endmodule